// File: doc/BRIEF.md
# Receive Frame Filter and Descriptor Writer

This block sits on the receive side of an Ethernet MAC. It takes incoming frames one byte per beat, decides from the destination address and the frame length whether a frame is kept, and copies each kept frame into the memory buffer named by the current receive descriptor. After a frame is stored, the block rewrites the descriptor's size word and moves along a linked chain of descriptors. Frame check sequence handling and the PHY side are done elsewhere.

A descriptor is three little-endian words at consecutive word addresses: buffer address at offset 0, size/flag word at offset 4 (bit 31 is the empty flag, bits 10:0 the byte count), and next-descriptor pointer at offset 8. Software writes the receive DMA control with the enable set to start the engine. The block then fetches the descriptor at the programmed base address. When it finds a descriptor that is not empty, it reports an overflow and switches its own DMA enable off.

Filtering uses the station address and two configuration words. One word holds drop requests for broadcast (bit 9) and multicast (bit 8). The other holds don't-care overrides at the same bit positions, and these win over the drop requests.

Top module: `eth_rx_filter_dma`

## Requirements
- R1: The first byte of a frame is accepted (`in_ready` high) only while both `mac_rx_en` and the DMA enable `dma_rx_en` are 1. `in_ready` is never high while `dma_rx_en` is 0.
- R2: A frame whose byte count exceeds `max_len[15:0]` produces no received pulse and leaves its descriptor's size word unchanged. A frame of exactly `max_len[15:0]` bytes is stored.
- R3: A destination of six 0xFF bytes is broadcast. It is accepted when `pass_cfg[9]` is 1, or when `drop_cfg[9]` is 0. The multicast bits do not affect it.
- R4: A non-broadcast frame whose first destination byte has bit 0 set is multicast. It is accepted when `pass_cfg[8]` is 1, or when `drop_cfg[8]` is 0. The broadcast bits do not affect it.
- R5: Any other frame is accepted only if all six destination bytes equal the station address. Octets 1..4 come from `sta_hi[31:0]`, most significant first, and octets 5..6 from `sta_lo[31:16]`. `sta_lo[15:0]` is ignored.
- R6: An accepted frame of length L, with an empty current descriptor, has byte i written to buffer address + i. The size word (offset 4) is then written as L[10:0], with bit 31 and all other bits 0. `rx_done` pulses for one cycle after that write.
- R7: After a stored frame, the next frame uses the descriptor at the stored frame's next pointer.
- R8: An accepted frame that meets a non-empty descriptor makes no memory writes. It pulses `rx_ovf` and clears `dma_rx_en`. `rx_ovf` and `rx_done` never pulse together.
- R9: A control write with `ctl_dma_en` = 1 sets `dma_rx_en` and loads the current descriptor pointer from `desc_base`, with bits 1:0 forced to 0.
- R10: A frame rejected by the address filter makes no memory writes and produces no pulse.
- R11: A frame shorter than six bytes is discarded with no memory write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_rx_en | input | 1 | MAC receive enable |
| ctl_wr | input | 1 | Strobe: receive DMA control written |
| ctl_dma_en | input | 1 | Enable value of that control write |
| desc_base | input | AW | Receive descriptor base address |
| sta_hi | input | 32 | Station address octets 1..4 |
| sta_lo | input | 32 | Station address octets 5..6 in bits 31:16 |
| drop_cfg | input | 32 | Drop requests: bit 9 broadcast, bit 8 multicast |
| pass_cfg | input | 32 | Don't-care overrides: bit 9 broadcast, bit 8 multicast |
| max_len | input | 32 | Maximum frame length in bits 15:0 |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_rd_en | output | 1 | Descriptor word read request |
| mem_rd_addr | output | AW | Read byte address (word aligned) |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_data | output | 32 | Write data (payload byte replicated in all lanes) |
| mem_wr_strb | output | 4 | Byte lane strobes |
| dma_rx_en | output | 1 | Current receive DMA enable |
| rx_done | output | 1 | Frame-stored pulse |
| rx_ovf | output | 1 | Descriptor-exhausted pulse |

## Verification
The assertions check on every cycle the behaviours that do not depend on frame contents. `in_ready` and every memory write occur only while the DMA enable is on. A payload write has exactly one strobe and a descriptor write has all four. Each received pulse follows a full-word size write, an overflow leaves the enable off, and the two pulses are never high together. Only the bench scenarios show the filter rules: the two-register priority for broadcast and multicast, the exact station match, and the length limit at its boundary. They also show the 11-bit size field on a long frame, the order in which descriptors are used along the chain, and the pointer reload on re-enable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HDR_BYTES = 6;
  localparam int unsigned EMPTY_POS = 31;
  localparam int unsigned BC_POS    = 9;
  localparam int unsigned MC_POS    = 8;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_FETCH,
    ST_IDLE,
    ST_HDR,
    ST_DECIDE,
    ST_FLUSH,
    ST_BODY,
    ST_END
  } rx_state_e;
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
(
  input  logic [8*HDR_BYTES-1:0] dest,
  input  logic [WORD_W-1:0]      sta_hi,
  input  logic [WORD_W-1:0]      sta_lo,
  input  logic [WORD_W-1:0]      drop_cfg,
  input  logic [WORD_W-1:0]      pass_cfg,
  output logic                   accept
);
  localparam int unsigned DW = 8 * HDR_BYTES;

  logic [DW-1:0] station;
  logic          is_bcast;
  logic          is_mcast;
  logic          bc_ok;
  logic          mc_ok;
  logic          unused_cfg;

  // first received byte sits in the top octet of both vectors
  assign station  = {sta_hi, sta_lo[WORD_W-1:WORD_W-16]};
  assign is_bcast = &dest;
  assign is_mcast = dest[DW-8];

  // override bit beats the drop request
  assign bc_ok = pass_cfg[BC_POS] | ~drop_cfg[BC_POS];
  assign mc_ok = pass_cfg[MC_POS] | ~drop_cfg[MC_POS];

  always_comb begin
    if (is_bcast) begin
      accept = bc_ok;
    end else if (is_mcast) begin
      accept = mc_ok;
    end else begin
      accept = (dest == station);
    end
  end

  assign unused_cfg = ^{sta_lo[WORD_W-17:0],
                        drop_cfg[WORD_W-1:BC_POS+1], drop_cfg[MC_POS-1:0],
                        pass_cfg[WORD_W-1:BC_POS+1], pass_cfg[MC_POS-1:0]};
endmodule

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture #(
  parameter int unsigned NB = 6,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [7:0]      wbyte,
  input  logic [IW-1:0]   ridx,
  output logic [7:0]      rbyte,
  output logic [8*NB-1:0] flat
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       byte_en;

    assign byte_en = we && (widx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= wbyte;
      end
    end

    assign flat[8*(NB-1-g) +: 8] = byte_q;
  end

  always_comb begin
    rbyte = '0;
    for (int i = 0; i < NB; i++) begin
      if (ridx == IW'(i)) begin
        rbyte = flat[8*(NB-1-i) +: 8];
      end
    end
  end
endmodule

// File: rtl/eth_rx_filter_dma.sv
module eth_rx_filter_dma
  import rxf_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned CNT_W  = 17,
  parameter int unsigned SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_rx_en,
  input  logic              ctl_wr,
  input  logic              ctl_dma_en,
  input  logic [AW-1:0]     desc_base,
  input  logic [WORD_W-1:0] sta_hi,
  input  logic [WORD_W-1:0] sta_lo,
  input  logic [WORD_W-1:0] drop_cfg,
  input  logic [WORD_W-1:0] pass_cfg,
  input  logic [WORD_W-1:0] max_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic [3:0]        mem_wr_strb,
  output logic              dma_rx_en,
  output logic              rx_done,
  output logic              rx_ovf
);
  localparam int unsigned     HIW        = $clog2(HDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BYTES - 1);
  localparam logic [HIW-1:0]   FLUSH_LAST = HIW'(HDR_BYTES - 1);
  localparam logic [1:0]       FETCH_END = 2'd3;
  localparam logic [AW-1:0]    SIZE_OFF  = AW'(4);

  logic rst_sn;

  rx_state_e        state_q, state_n;
  logic [AW-1:0]    cur_q, cur_n;
  logic [AW-1:0]    buf_q, buf_n;
  logic [AW-1:0]    nxt_q, nxt_n;
  logic             empty_q, empty_n;
  logic [1:0]       fidx_q, fidx_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             filt_q, filt_n;
  logic             last_q, last_n;
  logic [HIW-1:0]   flush_q, flush_n;
  logic             en_q, en_n;
  logic             done_q, done_n;
  logic             ovf_q, ovf_n;

  logic                   hdr_we;
  logic [HIW-1:0]         hdr_widx;
  logic [7:0]             hdr_rbyte;
  logic [8*HDR_BYTES-1:0] dest_flat;
  logic                   accept;

  logic [CNT_W-1:0] max_cnt;
  logic             too_long;
  logic             keep;
  logic             byte_we;
  logic [AW-1:0]    byte_off;
  logic [7:0]       byte_val;
  logic [AW-1:0]    byte_addr;
  logic             size_we;
  logic             unused_len;

  rxf_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rxf_hdr_capture #(.NB(HDR_BYTES)) i_hdr (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (hdr_we),
    .widx  (hdr_widx),
    .wbyte (in_data),
    .ridx  (flush_q),
    .rbyte (hdr_rbyte),
    .flat  (dest_flat)
  );

  rxf_addr_filter i_filter (
    .dest     (dest_flat),
    .sta_hi   (sta_hi),
    .sta_lo   (sta_lo),
    .drop_cfg (drop_cfg),
    .pass_cfg (pass_cfg),
    .accept   (accept)
  );

  assign max_cnt    = CNT_W'(max_len[15:0]);
  assign unused_len = ^max_len[WORD_W-1:16];
  assign too_long   = cnt_q > max_cnt;
  assign keep       = filt_q & empty_q;

  // next-state process
  always_comb begin
    state_n  = state_q;
    cur_n    = cur_q;
    buf_n    = buf_q;
    nxt_n    = nxt_q;
    empty_n  = empty_q;
    fidx_n   = fidx_q;
    cnt_n    = cnt_q;
    filt_n   = filt_q;
    last_n   = last_q;
    flush_n  = flush_q;
    en_n     = en_q;
    done_n   = 1'b0;
    ovf_n    = 1'b0;
    in_ready = 1'b0;
    mem_rd_en   = 1'b0;
    mem_rd_addr = cur_q + AW'({fidx_q, 2'b00});
    hdr_we   = 1'b0;
    hdr_widx = cnt_q[HIW-1:0];
    byte_we  = 1'b0;
    byte_off = AW'(cnt_q);
    byte_val = in_data;
    size_we  = 1'b0;

    unique case (state_q)
      ST_OFF: begin
      end
      ST_FETCH: begin
        mem_rd_en = (fidx_q != FETCH_END);
        fidx_n    = fidx_q + 2'd1;
        case (fidx_q)
          2'd1: buf_n   = AW'(mem_rd_data);
          2'd2: empty_n = mem_rd_data[EMPTY_POS];
          2'd3: begin
            nxt_n   = AW'(mem_rd_data);
            fidx_n  = 2'd0;
            state_n = ST_IDLE;
          end
          default: begin
          end
        endcase
      end
      ST_IDLE: begin
        in_ready = mac_rx_en & en_q;
        if (in_valid && mac_rx_en && en_q) begin
          hdr_we   = 1'b1;
          hdr_widx = '0;
          cnt_n    = CNT_W'(1);
          filt_n   = 1'b0;
          state_n  = in_last ? ST_END : ST_HDR;
        end
      end
      ST_HDR: begin
        in_ready = 1'b1;
        if (in_valid) begin
          hdr_we = 1'b1;
          cnt_n  = cnt_q + CNT_W'(1);
          if (cnt_q == HDR_LAST) begin
            last_n  = in_last;
            state_n = ST_DECIDE;
          end else if (in_last) begin
            state_n = ST_END;
          end
        end
      end
      ST_DECIDE: begin
        filt_n  = accept;
        flush_n = '0;
        if (accept && empty_q) begin
          state_n = ST_FLUSH;
        end else begin
          state_n = last_q ? ST_END : ST_BODY;
        end
      end
      ST_FLUSH: begin
        byte_off = AW'(flush_q);
        byte_val = hdr_rbyte;
        byte_we  = CNT_W'(flush_q) < max_cnt;
        flush_n  = flush_q + HIW'(1);
        if (flush_q == FLUSH_LAST) begin
          state_n = last_q ? ST_END : ST_BODY;
        end
      end
      ST_BODY: begin
        in_ready = 1'b1;
        if (in_valid) begin
          byte_we = keep && (cnt_q < max_cnt);
          cnt_n   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
          if (in_last) begin
            state_n = ST_END;
          end
        end
      end
      ST_END: begin
        if (filt_q && !too_long) begin
          if (empty_q) begin
            size_we = 1'b1;
            done_n  = 1'b1;
            cur_n   = nxt_q;
            fidx_n  = 2'd0;
            state_n = ST_FETCH;
          end else begin
            ovf_n   = 1'b1;
            en_n    = 1'b0;
            state_n = ST_OFF;
          end
        end else begin
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_OFF;
    endcase

    // a control write takes precedence over the sequence above
    if (ctl_wr) begin
      en_n   = ctl_dma_en;
      fidx_n = 2'd0;
      if (ctl_dma_en) begin
        cur_n   = {desc_base[AW-1:2], 2'b00};
        state_n = ST_FETCH;
      end else begin
        state_n = ST_OFF;
      end
    end
  end

  // memory write mux: size word or payload byte
  assign byte_addr   = buf_q + byte_off;
  assign mem_wr_en   = byte_we | size_we;
  assign mem_wr_addr = size_we ? (cur_q + SIZE_OFF) : byte_addr;
  assign mem_wr_data = size_we ? WORD_W'(cnt_q[SIZE_W-1:0]) : {4{byte_val}};
  assign mem_wr_strb = size_we ? 4'hF : (4'h1 << byte_addr[1:0]);

  // register process
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_OFF;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      empty_q <= 1'b0;
      fidx_q  <= '0;
      cnt_q   <= '0;
      filt_q  <= 1'b0;
      last_q  <= 1'b0;
      flush_q <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      buf_q   <= buf_n;
      nxt_q   <= nxt_n;
      empty_q <= empty_n;
      fidx_q  <= fidx_n;
      cnt_q   <= cnt_n;
      filt_q  <= filt_n;
      last_q  <= last_n;
      flush_q <= flush_n;
      en_q    <= en_n;
      done_q  <= done_n;
      ovf_q   <= ovf_n;
    end
  end

  assign dma_rx_en = en_q;
  assign rx_done   = done_q;
  assign rx_ovf    = ovf_q;
endmodule

// File: rtl/rxf_rx_chk.sv
module rxf_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       dma_rx_en,
  input logic       mem_wr_en,
  input logic [3:0] mem_wr_strb,
  input logic       rx_done,
  input logic       rx_ovf
);
  // R1
  ready_needs_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> dma_rx_en);

  // R10
  write_needs_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> dma_rx_en);

  // R6
  strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_strb == 4'hF || $countones(mem_wr_strb) == 1));

  // R6
  done_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(mem_wr_en && mem_wr_strb == 4'hF));

  // R8
  ovf_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> !dma_rx_en);

  // R8
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_ovf));
endmodule

bind eth_rx_filter_dma rxf_rx_chk i_rx_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .dma_rx_en   (dma_rx_en),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_strb (mem_wr_strb),
  .rx_done     (rx_done),
  .rx_ovf      (rx_ovf)
);

// File: tb/test_eth_rx_filter_dma.sv
`timescale 1ns/1ps
module test_eth_rx_filter_dma;
  localparam logic [31:0] STA_HI = 32'h0211_2233;
  localparam logic [31:0] STA_LO = 32'h4455_ABCD;
  localparam int NVEC = 12;
  // [25:24] dest kind, [23] drop b9, [22] drop b8, [21] pass b9, [20] pass b8,
  // [19:4] length, [0] expect stored
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd0, 4'b0000, 16'd20, 4'd1},
    {2'd1, 4'b0000, 16'd20, 4'd0},
    {2'd2, 4'b0000, 16'd24, 4'd1},
    {2'd2, 4'b1000, 16'd24, 4'd0},
    {2'd2, 4'b1010, 16'd24, 4'd1},
    {2'd3, 4'b0000, 16'd18, 4'd1},
    {2'd3, 4'b0100, 16'd18, 4'd0},
    {2'd3, 4'b0101, 16'd18, 4'd1},
    {2'd2, 4'b0100, 16'd22, 4'd1},
    {2'd3, 4'b1000, 16'd18, 4'd1},
    {2'd0, 4'b0000, 16'd6,  4'd1},
    {2'd0, 4'b0000, 16'd64, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic mac_rx_en, ctl_wr, ctl_dma_en;
  logic [31:0] desc_base, sta_hi, sta_lo, drop_cfg, pass_cfg, max_len;
  logic in_valid, in_last, in_ready;
  logic [7:0] in_data;
  logic mem_rd_en, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic [31:0] mem_rd_data;
  logic [3:0] mem_wr_strb;
  logic dma_rx_en, rx_done, rx_ovf;

  logic [31:0] mem [0:4095];
  int done_cnt, ovf_cnt, wr_cnt;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  eth_rx_filter_dma i_eth_rx_filter_dma (
    .clk(clk), .rst_n(rst_n), .mac_rx_en(mac_rx_en), .ctl_wr(ctl_wr),
    .ctl_dma_en(ctl_dma_en), .desc_base(desc_base), .sta_hi(sta_hi),
    .sta_lo(sta_lo), .drop_cfg(drop_cfg), .pass_cfg(pass_cfg),
    .max_len(max_len), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb),
    .dma_rx_en(dma_rx_en), .rx_done(rx_done), .rx_ovf(rx_ovf)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[13:2]];
    if (mem_wr_en) begin
      for (int b = 0; b < 4; b++)
        if (mem_wr_strb[b]) mem[mem_wr_addr[13:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      done_cnt <= 0; ovf_cnt <= 0; wr_cnt <= 0;
    end else begin
      if (rx_done) done_cnt <= done_cnt + 1;
      if (rx_ovf) ovf_cnt <= ovf_cnt + 1;
      if (mem_wr_en) wr_cnt <= wr_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] fbyte(int sel, int len, int i);
    logic [47:0] d;
    case (sel)
      0: d = 48'h0211_2233_4455;
      1: d = 48'h0211_2233_4456;
      2: d = 48'hFFFF_FFFF_FFFF;
      default: d = 48'h0100_5E00_0007;
    endcase
    if (i < 6) return d[8*(5-i) +: 8];
    return 8'(i * 13 + len);
  endfunction

  function automatic logic [7:0] mbyte(int addr);
    logic [31:0] w;
    w = mem[addr >> 2];
    return w[8*(addr % 4) +: 8];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(int sel, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbyte(sel, len, i);
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic ctl_write(logic en, logic [31:0] base);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_dma_en = en; desc_base = base;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int idx;
    int d0, w0, o0;
    rst_n = 1'b0; mac_rx_en = 1'b1; ctl_wr = 1'b0; ctl_dma_en = 1'b0;
    desc_base = '0; sta_hi = STA_HI; sta_lo = STA_LO;
    drop_cfg = '0; pass_cfg = '0; max_len = 32'h600;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    for (int k = 0; k < 16; k++) begin
      mem[k*4]     = 32'h1000 + k * 256;
      mem[k*4 + 1] = (k == 10) ? 32'h0000_0000 : 32'h8000_0000;
      mem[k*4 + 2] = (k + 1) * 16;
    end
    repeat (4) @(negedge clk);
    chk("R1 reset in_ready", {31'b0, in_ready}, 0);
    chk("R9 reset dma_rx_en", {31'b0, dma_rx_en}, 0);
    chk("R6 reset rx_done", {31'b0, rx_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready without dma enable", {31'b0, in_ready}, 0);

    ctl_write(1'b1, 32'h0);
    settle();
    chk("R9 dma enable set", {31'b0, dma_rx_en}, 1);
    chk("R1 ready with both enables", {31'b0, in_ready}, 1);
    mac_rx_en = 1'b0;
    #1;
    chk("R1 ready without mac enable", {31'b0, in_ready}, 0);
    @(negedge clk);
    mac_rx_en = 1'b1;

    idx = 0;
    for (int v = 0; v < NVEC; v++) begin
      int sel, len;
      string req;
      sel = int'(VEC[v][25:24]);
      len = int'(VEC[v][19:4]);
      req = (sel == 2) ? "R3" : (sel == 3) ? "R4" : "R5";
      @(negedge clk);
      drop_cfg = {22'b0, VEC[v][23], VEC[v][22], 8'h00};
      pass_cfg = {22'b0, VEC[v][21], VEC[v][20], 8'h00};
      d0 = done_cnt; w0 = wr_cnt;
      send_frame(sel, len);
      settle();
      if (VEC[v][0]) begin
        chk({req, " accepted frame pulse"}, done_cnt - d0, 1);
        chk("R6 size word", mem[idx*4 + 1], len);
        chk("R6 first byte", {24'b0, mbyte(32'h1000 + idx*256)}, {24'b0, fbyte(sel, len, 0)});
        chk("R7 last byte in chained buffer",
            {24'b0, mbyte(32'h1000 + idx*256 + len - 1)}, {24'b0, fbyte(sel, len, len - 1)});
        idx++;
      end else begin
        chk({req, " rejected frame pulse"}, done_cnt - d0, 0);
        chk("R10 rejected frame writes", wr_cnt - w0, 0);
      end
    end

    // length limit, one over then exactly at the limit (descriptor 9)
    max_len = 32'h0001_0014;
    d0 = done_cnt;
    send_frame(0, 21);
    settle();
    chk("R2 oversize no pulse", done_cnt - d0, 0);
    chk("R2 oversize descriptor untouched", mem[9*4 + 1], 32'h8000_0000);
    send_frame(0, 20);
    settle();
    chk("R2 frame at limit stored", done_cnt - d0, 1);
    chk("R2 size word at limit", mem[9*4 + 1], 20);
    max_len = 32'h600;

    // short frame
    d0 = done_cnt; w0 = wr_cnt; o0 = ovf_cnt;
    send_frame(0, 4);
    settle();
    chk("R11 runt no pulse", (done_cnt - d0) + (ovf_cnt - o0), 0);
    chk("R11 runt no writes", wr_cnt - w0, 0);

    // descriptor 10 is not empty
    d0 = done_cnt; w0 = wr_cnt; o0 = ovf_cnt;
    send_frame(0, 16);
    settle();
    chk("R8 overflow pulse", ovf_cnt - o0, 1);
    chk("R8 no store on overflow", (done_cnt - d0) + (wr_cnt - w0), 0);
    chk("R8 dma enable cleared", {31'b0, dma_rx_en}, 0);
    chk("R8 descriptor left as is", mem[10*4 + 1], 32'h0);
    chk("R1 ready after overflow", {31'b0, in_ready}, 0);

    // re-enable at descriptor 11, low address bits ignored
    ctl_write(1'b1, 32'h0000_00B2);
    settle();
    d0 = done_cnt;
    send_frame(0, 30);
    settle();
    chk("R9 reload pointer pulse", done_cnt - d0, 1);
    chk("R9 stored in reloaded descriptor", mem[11*4 + 1], 30);
    chk("R9 reloaded buffer byte", {24'b0, mbyte(32'h1000 + 11*256)}, {24'b0, fbyte(0, 30, 0)});

    // long frame: size field keeps bits 10:0 only (descriptor 12)
    max_len = 32'h0000_FFFF;
    send_frame(0, 2050);
    settle();
    chk("R6 size field wraps at 11 bits", mem[12*4 + 1], 2050 % 2048);
    chk("R6 long frame last byte", {24'b0, mbyte(32'h1000 + 12*256 + 2049)}, {24'b0, fbyte(0, 2050, 2049)});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule